// File: doc/BRIEF.md
# Scatter Segment to Descriptor Splitter

This block turns a list of scatter-gather segments into a physical region descriptor table for a bus-mastering disk DMA engine. Each segment is a 32-bit bus address and a byte length, and it arrives on a valid/ready handshake with a last flag. The block cuts every segment into regions that never span a 64 KiB address boundary. For each region it writes two 32-bit words to a descriptor memory port, one word per clock: first the region's address, then its count/flag word.

At the end of each table the block gives a one-cycle done pulse with a success flag and the number of entries written. Failure tells the caller to move the request by programmed I/O instead. Two mode inputs shape the output:
- The zero-count workaround serves hosts that read a 0x0000 count as zero bytes rather than 64 KiB.
- The alternate count format is for hosts that take a 32-bit-unit count in the upper half of the word.

Both mode inputs must stay stable for the whole of one table.

Top module: `prd_splitter`

## Requirements
- R1: Each region's length is the smaller of the bytes left in the segment and 0x10000 minus the low 16 address bits, so no region crosses a 64 KiB boundary. The next region starts at the previous address plus that length.
- R2: Entry n is written as two words on consecutive cycles: the address word at word index 2n, then the count word at index 2n+1. In normal format the count word holds the low 16 bits of the region length in bits 15:0, where 0x0000 means 64 KiB. Bits 30:16 are zero.
- R3: In normal format, bit 31 of the count word is set on the final entry of a successful table and is clear on every other entry.
- R4: When the zero-count workaround is enabled in normal format, a 64 KiB region at address A becomes two entries. The first is (A, 0x8000) and the second is (A+0x8000, 0x8000). No count word with bits 15:0 equal to zero is written.
- R5: In alternate format the count word is ((length[15:0] >> 2) - 1) mod 65536 in bits 31:16, with bits 15:0 zero. No end-of-table bit is set, and the zero-count workaround has no effect.
- R6: If another entry is needed when MAX_ENTRIES entries have already been written, no further word is written. The remaining segments up to and including the last one are accepted and discarded. Done then reports failure with a count of 0.
- R7: A table whose segments all have zero length reports failure with a count of 0 and writes nothing. Zero-length segments produce no entry.
- R8: If the last segment has zero length and entries exist, the block rewrites the previous count word (index 2n-1) with bit 31 set in normal format. In alternate format it writes nothing.
- R9: Done is a single-cycle pulse after the table's last write. On success, ok is 1 and the count is the number of entries. Segment ready is low on every cycle in which a descriptor word is written.
- R10: After reset, segment ready is 1 and done and the memory write enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_fmt_i | input | 1 | Selects the alternate count format |
| split_zero_i | input | 1 | Enables the 64 KiB zero-count workaround |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment accepted this cycle when valid |
| seg_addr_i | input | 32 | Segment bus address |
| seg_len_i | input | LEN_W | Segment length in bytes |
| seg_last_i | input | 1 | Final segment of the table |
| mem_we_o | output | 1 | Descriptor word write enable |
| mem_addr_o | output | IDX_W | Descriptor word index |
| mem_data_o | output | 32 | Descriptor word |
| done_o | output | 1 | Table finished pulse |
| ok_o | output | 1 | Table built successfully (valid with done) |
| count_o | output | CNT_W | Entries written (valid with done) |

## Verification
The assertions watch every write on every cycle. They check that an address word is always followed by its count word at the next index, that no normal-format region runs past a 64 KiB boundary, and that the count-word fields obey the selected format and the zero-count workaround. They also check that ready is low during writes, that done is a single pulse, and that the reported count agrees with the result. Only the bench scenarios can show the following: the exact region sequence for unaligned and multi-segment inputs, where the end bit lands, the rewrite after a trailing empty segment, the abort point at the entry limit together with the discarding of later segments, and the outcome for an empty table.

// File: rtl/prd_pkg.sv
// Shared types for the descriptor splitter.
// Assumes: one table is built at a time; mode inputs are stable per table.
package prd_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned SPAN_W = 17; // region length up to 0x10000

    typedef enum logic [2:0] {
        ST_TAKE = 3'd0,
        ST_ADDR = 3'd1,
        ST_CNT  = 3'd2,
        ST_FIX  = 3'd3,
        ST_DONE = 3'd4
    } split_state_e;
endpackage

// File: rtl/prd_chunker.sv
// Region length calculator: limits a region to the next 64 KiB boundary
// and applies the zero-count workaround by halving full 64 KiB regions.
// Assumes: LEN_W >= 17.
module prd_chunker #(
    parameter int unsigned LEN_W = 32
) (
    input  logic [15:0]          addr_lo,
    input  logic [LEN_W-1:0]     remain,
    input  logic                 split_en,
    input  logic                 alt_fmt,
    output logic [prd_pkg::SPAN_W-1:0] chunk,
    output logic                 final_o
);
    import prd_pkg::*;
    logic [SPAN_W-1:0] to_edge;
    logic [SPAN_W-1:0] raw;

    // Pick the shorter of boundary distance and bytes left, then split 64 KiB.
    always_comb begin
        to_edge = 17'h10000 - {1'b0, addr_lo};
        if (remain < LEN_W'(to_edge)) raw = remain[SPAN_W-1:0];
        else                          raw = to_edge;
        if (split_en && !alt_fmt && raw == 17'h10000) chunk = 17'h08000;
        else                                          chunk = raw;
        final_o = (remain == LEN_W'(chunk));
    end
endmodule

// File: rtl/prd_word_fmt.sv
// Count/flag word encoder for the normal and alternate formats.
// Assumes: alternate-format lengths are multiples of 4 bytes.
module prd_word_fmt (
    input  logic [prd_pkg::SPAN_W-1:0] chunk,
    input  logic                       alt_fmt,
    input  logic                       eot,
    output logic [prd_pkg::WORD_W-1:0] word
);
    logic [15:0] units;

    // Build the count word for the selected format.
    always_comb begin
        units = (chunk[15:0] >> 2) - 16'd1;
        if (alt_fmt) word = {units, 16'h0000};
        else         word = {eot, 15'b0, chunk[15:0]};
    end
endmodule

// File: rtl/prd_entry_ctr.sv
// Entry counter with a limit flag; cleared at the end of each table.
// Assumes: inc is never asserted while full.
module prd_entry_ctr #(
    parameter int unsigned MAX_ENTRIES = 256,
    localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    // Count written entries.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + 1'b1;
    end

    // Flag that the table has no free slot.
    always_comb full = (count == CNT_W'(MAX_ENTRIES));
endmodule

// File: rtl/prd_splitter.sv
// Scatter segment to descriptor table splitter (top).
// Accepts segments, emits address/count word pairs one word per clock,
// enforces the entry limit and reports the outcome with a done pulse.
// Assumes: normal-format addresses 2-byte aligned, alternate 4-byte aligned.
module prd_splitter #(
    parameter int unsigned LEN_W       = 32,
    parameter int unsigned MAX_ENTRIES = 256,
    localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1),
    localparam int unsigned IDX_W = $clog2(2 * MAX_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_fmt_i,
    input  logic             split_zero_i,
    input  logic             seg_valid_i,
    output logic             seg_ready_o,
    input  logic [31:0]      seg_addr_i,
    input  logic [LEN_W-1:0] seg_len_i,
    input  logic             seg_last_i,
    output logic             mem_we_o,
    output logic [IDX_W-1:0] mem_addr_o,
    output logic [31:0]      mem_data_o,
    output logic             done_o,
    output logic             ok_o,
    output logic [CNT_W-1:0] count_o
);
    import prd_pkg::*;

    split_state_e      state_q;
    logic [31:0]       cur_addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic              last_q;
    logic              fail_q;
    logic [31:0]       prev_word_q;
    logic [SPAN_W-1:0] chunk;
    logic              chunk_final;
    logic [31:0]       cnt_word;
    logic [CNT_W-1:0]  count;
    logic              full;
    logic              seg_fire;
    logic [CNT_W-1:0]  count_m1;

    prd_chunker #(.LEN_W(LEN_W)) u_chunk (
        .addr_lo (cur_addr_q[15:0]),
        .remain  (remain_q),
        .split_en(split_zero_i),
        .alt_fmt (alt_fmt_i),
        .chunk   (chunk),
        .final_o (chunk_final)
    );

    prd_word_fmt u_fmt (
        .chunk  (chunk),
        .alt_fmt(alt_fmt_i),
        .eot    (last_q && chunk_final),
        .word   (cnt_word)
    );

    prd_entry_ctr #(.MAX_ENTRIES(MAX_ENTRIES)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == ST_DONE),
        .inc  (state_q == ST_CNT),
        .count(count),
        .full (full)
    );

    // Handshake and index helpers.
    always_comb begin
        seg_ready_o = (state_q == ST_TAKE);
        seg_fire    = seg_ready_o && seg_valid_i;
        count_m1    = count - 1'b1;
    end

    // Memory write port and completion outputs.
    always_comb begin
        mem_we_o   = 1'b0;
        mem_addr_o = '0;
        mem_data_o = '0;
        case (state_q)
            ST_ADDR: if (!full) begin
                mem_we_o   = 1'b1;
                mem_addr_o = {count[IDX_W-2:0], 1'b0};
                mem_data_o = cur_addr_q;
            end
            ST_CNT: begin
                mem_we_o   = 1'b1;
                mem_addr_o = {count[IDX_W-2:0], 1'b1};
                mem_data_o = cnt_word;
            end
            ST_FIX: if (!alt_fmt_i) begin
                mem_we_o   = 1'b1;
                mem_addr_o = {count_m1[IDX_W-2:0], 1'b1};
                mem_data_o = prev_word_q | 32'h8000_0000;
            end
            default: ;
        endcase
        done_o  = (state_q == ST_DONE);
        ok_o    = done_o && !fail_q && (count != '0);
        count_o = ok_o ? count : '0;
    end

    // Sequencer: accept, emit address, emit count, fix-up, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_TAKE;
            cur_addr_q  <= '0;
            remain_q    <= '0;
            last_q      <= 1'b0;
            fail_q      <= 1'b0;
            prev_word_q <= '0;
        end else begin
            case (state_q)
                ST_TAKE: if (seg_fire) begin
                    cur_addr_q <= seg_addr_i;
                    remain_q   <= seg_len_i;
                    last_q     <= seg_last_i;
                    if (fail_q) begin
                        if (seg_last_i) state_q <= ST_DONE;
                    end else if (seg_len_i == '0) begin
                        if (seg_last_i)
                            state_q <= (count != '0) ? ST_FIX : ST_DONE;
                    end else begin
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (full) begin
                        fail_q  <= 1'b1;
                        state_q <= last_q ? ST_DONE : ST_TAKE;
                    end else begin
                        state_q <= ST_CNT;
                    end
                end
                ST_CNT: begin
                    prev_word_q <= cnt_word;
                    cur_addr_q  <= cur_addr_q + 32'(chunk);
                    remain_q    <= remain_q - LEN_W'(chunk);
                    if (chunk_final) state_q <= last_q ? ST_DONE : ST_TAKE;
                    else             state_q <= ST_ADDR;
                end
                ST_FIX:  state_q <= ST_DONE;
                ST_DONE: begin
                    fail_q  <= 1'b0;
                    state_q <= ST_TAKE;
                end
                default: state_q <= ST_TAKE;
            endcase
        end
    end
endmodule

// File: rtl/prd_splitter_chk.sv
// Property checker for prd_splitter, attached with bind.
module prd_splitter_chk #(
    parameter int unsigned MAX_ENTRIES = 256,
    localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1),
    localparam int unsigned IDX_W = $clog2(2 * MAX_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alt_fmt_i,
    input logic             split_zero_i,
    input logic             seg_ready_o,
    input logic             mem_we_o,
    input logic [IDX_W-1:0] mem_addr_o,
    input logic [31:0]      mem_data_o,
    input logic             done_o,
    input logic             ok_o,
    input logic [CNT_W-1:0] count_o
);
    logic [15:0] addr_lo_q;
    logic [16:0] span;

    // Remember the low bits of the most recent address word.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_lo_q <= '0;
        else if (mem_we_o && !mem_addr_o[0]) addr_lo_q <= mem_data_o[15:0];
    end

    // Decode the normal-format region length.
    always_comb span = (mem_data_o[15:0] == 16'h0) ? 17'h10000 : {1'b0, mem_data_o[15:0]};

    p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o[0] && !alt_fmt_i) |-> ({1'b0, addr_lo_q} + span <= 17'h10000));
    p_pair_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !mem_addr_o[0]) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + 1'b1));
    p_norm_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o[0] && !alt_fmt_i) |-> (mem_data_o[30:16] == 15'h0));
    p_no_zero_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o[0] && split_zero_i && !alt_fmt_i) |-> (mem_data_o[15:0] != 16'h0));
    p_alt_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o[0] && alt_fmt_i) |-> (mem_data_o[15:0] == 16'h0));
    p_fail_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> (count_o == '0));
    p_ok_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> (count_o != '0 && count_o <= CNT_W'(MAX_ENTRIES)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !seg_ready_o);
endmodule

bind prd_splitter prd_splitter_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alt_fmt_i   (alt_fmt_i),
    .split_zero_i(split_zero_i),
    .seg_ready_o (seg_ready_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .count_o     (count_o)
);

// File: tb/prd_splitter_tb.sv
module prd_splitter_tb;
    localparam int unsigned LEN_W = 32;
    localparam int unsigned MAXE  = 8;
    localparam int unsigned CNT_W = $clog2(MAXE + 1);
    localparam int unsigned IDX_W = $clog2(2 * MAXE);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alt_fmt_i = 1'b0, split_zero_i = 1'b0;
    logic seg_valid_i = 1'b0, seg_last_i = 1'b0;
    logic [31:0] seg_addr_i = '0;
    logic [LEN_W-1:0] seg_len_i = '0;
    logic seg_ready_o, mem_we_o, done_o, ok_o;
    logic [IDX_W-1:0] mem_addr_o;
    logic [31:0] mem_data_o;
    logic [CNT_W-1:0] count_o;

    int checks = 0, fails = 0, dones = 0;
    int exp_idx[$];
    logic [31:0] exp_dat[$];
    string exp_tag[$];
    logic exp_ok[$];
    int exp_cnt[$];
    longint seg_a[$], seg_l[$];
    logic prev_done = 1'b0;

    always #5 clk = ~clk;

    prd_splitter #(.LEN_W(LEN_W), .MAX_ENTRIES(MAXE)) u_dut (.*);

    // Monitor: compare every write and every done against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we_o) begin
                checks++;
                if (exp_idx.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected write idx=%0d data=%h expected none", mem_addr_o, mem_data_o);
                end else begin
                    int ei; logic [31:0] ed; string et;
                    ei = exp_idx.pop_front(); ed = exp_dat.pop_front(); et = exp_tag.pop_front();
                    if (int'(mem_addr_o) != ei || mem_data_o != ed) begin
                        fails++;
                        $display("FAIL %s write idx=%0d data=%h expected idx=%0d data=%h", et, mem_addr_o, mem_data_o, ei, ed);
                    end
                end
            end
            if (done_o) begin
                checks++;
                if (exp_ok.size() == 0) begin
                    fails++;
                    $display("FAIL R9 unexpected done ok=%0d expected none", ok_o);
                end else begin
                    logic eo; int ec;
                    eo = exp_ok.pop_front(); ec = exp_cnt.pop_front();
                    if (ok_o != eo || int'(count_o) != ec) begin
                        fails++;
                        $display("FAIL R7/R9 done ok=%0d count=%0d expected ok=%0d count=%0d", ok_o, count_o, eo, ec);
                    end
                end
                dones++;
            end
            if (prev_done) begin
                checks++;
                if (done_o) begin
                    fails++;
                    $display("FAIL R9 done width: actual 2+ cycles expected 1");
                end
            end
            prev_done = done_o;
        end
    end

    // Reference model: compute expected writes and outcome from the requirements.
    task automatic plan(input bit split, input bit alt);
        int count = 0; bit fail = 0; logic [31:0] lastw = '0;
        for (int s = 0; s < seg_a.size() && !fail; s++) begin
            longint a = seg_a[s], l = seg_l[s];
            bit lastseg = (s == seg_a.size() - 1);
            while (l > 0) begin
                longint bnd, c; logic [31:0] cw; logic [15:0] u;
                if (count == MAXE) begin fail = 1; break; end
                bnd = 64'h10000 - (a & 64'hFFFF);
                c = (l < bnd) ? l : bnd;
                if (split && !alt && c == 64'h10000) c = 64'h8000;
                u = (16'(c) >> 2) - 16'd1;
                cw = alt ? {u, 16'h0} : {15'b0, 1'b0, 16'(c)};
                lastw = cw;
                if (!alt && lastseg && l == c) cw[31] = 1'b1;
                exp_idx.push_back(2*count);   exp_dat.push_back(32'(a)); exp_tag.push_back("R1/R2 addr");
                exp_idx.push_back(2*count+1); exp_dat.push_back(cw);
                exp_tag.push_back(alt ? "R5 count" : (split ? "R3/R4 count" : "R2/R3 count"));
                count++; a += c; l -= c;
            end
        end
        if (!fail && count > 0 && !alt && seg_l[seg_l.size()-1] == 0) begin
            exp_idx.push_back(2*count-1); exp_dat.push_back(lastw | 32'h8000_0000); exp_tag.push_back("R8 rewrite");
        end
        exp_ok.push_back(!fail && count > 0);
        exp_cnt.push_back((!fail && count > 0) ? count : 0);
    endtask

    // Driver: plan the case, send all segments, wait for completion.
    task automatic run_case(input string name, input bit split, input bit alt);
        int d0 = dones;
        @(negedge clk);
        split_zero_i = split; alt_fmt_i = alt;
        plan(split, alt);
        for (int s = 0; s < seg_a.size(); s++) begin
            seg_addr_i = 32'(seg_a[s]); seg_len_i = LEN_W'(seg_l[s]);
            seg_last_i = (s == seg_a.size() - 1); seg_valid_i = 1'b1;
            while (!seg_ready_o) @(negedge clk);
            @(negedge clk);
            seg_valid_i = 1'b0;
        end
        while (dones == d0) @(negedge clk);
        @(negedge clk);
        checks++;
        if (exp_idx.size() != 0 || exp_ok.size() != 0) begin
            fails++;
            $display("FAIL R6 %s: %0d writes still expected, expected 0", name, exp_idx.size());
            exp_idx.delete(); exp_dat.delete(); exp_tag.delete(); exp_ok.delete(); exp_cnt.delete();
        end
        seg_a.delete(); seg_l.delete();
    endtask

    task automatic add(input longint a, input longint l);
        seg_a.push_back(a); seg_l.push_back(l);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++; // R10 reset state
        if (seg_ready_o !== 1'b1 || done_o !== 1'b0 || mem_we_o !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: ready=%b done=%b we=%b expected 1 0 0", seg_ready_o, done_o, mem_we_o);
        end
        add(32'h1000_0000, 32'h200);                         run_case("single", 0, 0);   // R2 R3
        add(32'h0001_FF00, 32'h300);                         run_case("cross", 0, 0);    // R1
        add(32'h0000_0100, 32'h80); add(32'h0002_FFF0, 32'h40);
        add(32'h0040_0000, 32'h1000);                        run_case("multi", 0, 0);    // R1 R3
        add(32'h0030_0000, 32'h10000);                       run_case("full64", 0, 0);   // R2
        add(32'h0030_0000, 32'h18000);                       run_case("split", 1, 0);    // R4
        add(32'h0000_2000, 32'h400); add(32'h0005_0000, 32'h10000);
                                                             run_case("alt", 1, 1);      // R5
        add(32'h0000_4000, 32'h100); add(32'h0, 32'h0);      run_case("trail0", 0, 0);   // R8
        add(32'h0000_4000, 32'h100); add(32'h0, 32'h0);      run_case("trail0alt", 0, 1);// R8
        add(32'h0, 32'h0); add(32'h0, 32'h0);                run_case("empty", 0, 0);    // R7
        add(32'h0010_0000, 32'h90000); add(32'h0, 32'h200);  run_case("overflow", 0, 0); // R6
        add(32'h0010_0000, 32'h40000);                       run_case("exactmax", 1, 0); // R6 R4
        add(32'h0020_8000, 32'h28000);                       run_case("midsplit", 1, 0); // R4 R1
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule